// File: doc/BRIEF.md
# Two-Wire Handshake Parallel Port

This block moves bytes between a CPU-side stream and an 8-bit external data bus, using two handshake wires: an active-low data-available strobe and an active-high ready line. A single configuration input picks the direction. When the port receives, the peripheral places a byte on the bus and pulls the strobe low. The port captures the byte, pulls ready low to acknowledge it, and presents the byte to the CPU. When the port transmits, it drives the byte and then lowers its own strobe. It waits for the peripheral to drop ready, releases the strobe, and then waits for ready to come back before it takes the next byte.

Both handshake inputs cross into the clock domain through multi-flop synchronizers, so each reaction to a pin edge comes a fixed number of cycles after that edge. Both CPU-side interfaces are valid/ready. A received byte stays in `rx_data` with `rx_valid` high until a cycle with `rx_ready` high. As long as it is unread, the external ready line stays low, so the peripheral is held off. On the transmit side, `tx_ready` is high only while the output handshake is idle. A transfer starts on a cycle where both `tx_valid` and `tx_ready` are high.

Top module: `hs_port`

## Requirements
- R1: While reset is applied and right after it, `rdy_out` is 1, `dav_n_out` is 1, `rx_valid` is 0 and `tx_ready` is 0 (reset leaves `dir_out` at 0, which selects input mode).
- R2: In input mode (`dir_out`=0), once `dav_n_in` goes low, `rdy_out` goes low after exactly SYNC_STAGES+1 rising edges (3 at default settings). `rx_valid` goes high on the same edge.
- R3: The byte on `pin_din` is captured on that edge. `rx_data` keeps that byte even if `pin_din` changes afterwards. Received bytes are delivered in order.
- R4: Back-pressure on receive: while `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` and `rx_data` do not change and `rdy_out` stays low, even after `dav_n_in` has gone high. If `dav_n_in` is already high, `rdy_out` returns to 1 on the same edge that completes the read.
- R5: If the byte has already been read, `rdy_out` returns to 1 exactly SYNC_STAGES+1 edges after `dav_n_in` goes high.
- R6: In input mode the transmit side has no effect: `tx_ready` is 0, `dav_n_out` is 1 and `pin_doe` is 0, whatever `tx_valid` does.
- R7: In output mode (`dir_out`=1) with the handshake idle, `tx_ready` is 1. One edge after a `tx_valid`/`tx_ready` transfer, `pin_dout` shows the byte and `pin_doe` is 1. `dav_n_out` goes low SETUP_CYC edges after that (2 at default settings).
- R8: `dav_n_out` stays low while `rdy_in` stays high. After `rdy_in` falls, `dav_n_out` goes high exactly SYNC_STAGES+1 edges later.
- R9: `tx_ready` stays 0 until SYNC_STAGES+1+GAP_CYC edges after `rdy_in` rises again (5 at default settings). No byte is accepted before then.
- R10: `pin_dout` does not change while `dav_n_out` is low. The bytes strobed out match the accepted bytes, in order.
- R11: In output mode, `dav_n_in` has no effect: `rx_valid` stays 0 and `rdy_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Direction select: 0 receive, 1 transmit |
| pin_din | input | DW | External bus value seen by the port |
| dav_n_in | input | 1 | Peripheral data-available strobe, active low (input mode) |
| rdy_out | output | 1 | Port acknowledge / ready to the peripheral (input mode) |
| pin_dout | output | DW | Byte driven onto the external bus |
| pin_doe | output | 1 | Bus drive enable, high in output mode |
| dav_n_out | output | 1 | Port data-available strobe, active low (output mode) |
| rdy_in | input | 1 | Peripheral ready line (output mode) |
| rx_data | output | DW | Received byte to the CPU |
| rx_valid | output | 1 | Received byte is waiting |
| rx_ready | input | 1 | CPU takes the received byte |
| tx_data | input | DW | Byte from the CPU to send |
| tx_valid | input | 1 | CPU offers a byte |
| tx_ready | output | 1 | Port accepts a byte this cycle |

## Verification
On the receive side, `rdy_out` and `rx_valid` are due three edges after a strobe edge driven on a falling clock edge. `rdy_out` rises either three edges after the strobe returns high or on the edge that completes the CPU read. On the transmit side, the pins are due one edge after acceptance and the strobe two edges after that; the strobe releases three edges after `rdy_in` falls, and `tx_ready` returns five edges after `rdy_in` rises. The bench drives each stimulus on a falling clock edge and counts falling edges before it samples. It checks both the cycle just before each transition and the cycle where the transition is due, so an extra or a missing pipeline stage is caught. Queue monitors compare the byte values in the cycle the CPU read completes and in the cycle the port's strobe falls.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_HELD = 1'b1
  } rx_state_t;

  typedef enum logic [2:0] {
    TX_IDLE    = 3'd0,
    TX_SETUP   = 3'd1,
    TX_STROBE  = 3'd2,
    TX_RELEASE = 3'd3,
    TX_GAP     = 3'd4
  } tx_state_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx
  import hsp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dav_s,
  input  logic [DW-1:0] pin_din,
  output logic          rdy_out,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready
);
  rx_state_t state;
  logic      take;

  assign take = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (take) rx_valid <= 1'b0;
      if (en) begin
        case (state)
          RX_IDLE: begin
            if (!dav_s) begin
              rx_data  <= pin_din;
              rx_valid <= 1'b1;
              state    <= RX_HELD;
            end
          end
          RX_HELD: begin
            if (dav_s && (!rx_valid || rx_ready)) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign rdy_out = !en || (state == RX_IDLE);
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx
  import hsp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int GAP_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rdy_s,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] pin_dout,
  output logic          dav_n_out
);
  localparam int MAXC = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  tx_state_t     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      cnt      <= '0;
      pin_dout <= '0;
    end else if (!en) begin
      state <= TX_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (tx_valid) begin
            pin_dout <= tx_data;
            cnt      <= CW'(SETUP_CYC - 1);
            state    <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          if (cnt == '0) state <= TX_STROBE;
          else           cnt   <= cnt - 1'b1;
        end
        TX_STROBE: begin
          if (!rdy_s) state <= TX_RELEASE;
        end
        TX_RELEASE: begin
          if (rdy_s) begin
            cnt   <= CW'(GAP_CYC - 1);
            state <= TX_GAP;
          end
        end
        TX_GAP: begin
          if (cnt == '0) state <= TX_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign tx_ready  = en && (state == TX_IDLE);
  assign dav_n_out = (state != TX_STROBE);
endmodule

// File: rtl/hs_port.sv
module hs_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 2,
  parameter int GAP_CYC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_out,
  input  logic [DW-1:0] pin_din,
  input  logic          dav_n_in,
  output logic          rdy_out,
  output logic [DW-1:0] pin_dout,
  output logic          pin_doe,
  output logic          dav_n_out,
  input  logic          rdy_in,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready
);
  logic dav_sync;
  logic rdy_sync;

  hsp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dav_sync (
    .clk(clk), .rst_n(rst_n), .d(dav_n_in), .q(dav_sync)
  );

  hsp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_sync)
  );

  hsp_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!dir_out),
    .dav_s    (dav_sync),
    .pin_din  (pin_din),
    .rdy_out  (rdy_out),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready)
  );

  hsp_tx #(.DW(DW), .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (dir_out),
    .rdy_s     (rdy_sync),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .pin_dout  (pin_dout),
    .dav_n_out (dav_n_out)
  );

  assign pin_doe = dir_out;
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_out,
  input logic          rdy_out,
  input logic [DW-1:0] pin_dout,
  input logic          pin_doe,
  input logic          dav_n_out,
  input logic          rdy_sync,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_ready
);
  AST_RDY_DROP_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && $fell(rdy_out)) |-> rx_valid); // R2

  AST_RX_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R4

  AST_INPUT_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && !$past(dir_out)) |-> (dav_n_out && !tx_ready && !pin_doe)); // R6

  AST_STROBE_NEEDS_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && $rose(dav_n_out)) |-> !$past(rdy_sync)); // R8

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (dav_n_out && dir_out)); // R9

  AST_PINS_STEADY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !dav_n_out |-> $stable(pin_dout)); // R10
endmodule

bind hs_port hs_port_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_out   (dir_out),
  .rdy_out   (rdy_out),
  .pin_dout  (pin_dout),
  .pin_doe   (pin_doe),
  .dav_n_out (dav_n_out),
  .rdy_sync  (rdy_sync),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_ready  (tx_ready)
);

// File: tb/hs_port_test.sv
`timescale 1ns/1ps
module hs_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_out;
  logic [7:0] pin_din;
  logic       dav_n_in;
  logic       rdy_out;
  logic [7:0] pin_dout;
  logic       pin_doe;
  logic       dav_n_out;
  logic       rdy_in;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] exp_tx[$];
  logic prev_dav = 1'b1;

  always #2 clk = ~clk;

  hs_port uut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .pin_din(pin_din),
    .dav_n_in(dav_n_in), .rdy_out(rdy_out), .pin_dout(pin_dout),
    .pin_doe(pin_doe), .dav_n_out(dav_n_out), .rdy_in(rdy_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Receive monitor: a read completes at the next edge when valid and ready are both high
  always @(negedge clk) begin
    #1;
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_rx.size() == 0) chk("R3 unexpected byte", rx_data, 32'hFFFF);
      else chk("R3 received byte", rx_data, exp_rx.pop_front());
    end
  end

  // Transmit monitor: compares the bus when the port's strobe falls
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_dav && !dav_n_out) begin
        if (exp_tx.size() == 0) chk("R10 unexpected strobe", pin_dout, 32'hFFFF);
        else chk("R10 strobed byte", pin_dout, exp_tx.pop_front());
      end
      prev_dav = dav_n_out;
    end
  end

  task automatic in_byte(input logic [7:0] b, input bit read_early);
    @(negedge clk);
    pin_din = b; dav_n_in = 1'b0; exp_rx.push_back(b);
    repeat (2) @(negedge clk);
    chk("R2 rdy before due", rdy_out, 1);
    @(negedge clk);
    chk("R2 rdy low", rdy_out, 0);
    chk("R2 valid", rx_valid, 1);
    pin_din = ~b;
    if (read_early) begin
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0; dav_n_in = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 rdy before due", rdy_out, 0);
      @(negedge clk);
      chk("R5 rdy high", rdy_out, 1);
    end else begin
      dav_n_in = 1'b1;
      repeat (10) @(negedge clk);
      chk("R4 rdy held low", rdy_out, 0);
      chk("R4 valid held", rx_valid, 1);
      chk("R3 data latched", rx_data, b);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      chk("R4 rdy after read", rdy_out, 1);
      chk("R4 valid cleared", rx_valid, 0);
    end
  endtask

  task automatic out_byte(input logic [7:0] b);
    @(negedge clk);
    chk("R7 idle ready", tx_ready, 1);
    tx_data = b; tx_valid = 1'b1; exp_tx.push_back(b);
    @(negedge clk);
    tx_valid = 1'b0; tx_data = 8'h00;
    chk("R7 pins", pin_dout, b);
    chk("R7 drive enable", pin_doe, 1);
    chk("R7 strobe not yet", dav_n_out, 1);
    @(negedge clk);
    chk("R7 strobe not yet", dav_n_out, 1);
    @(negedge clk);
    chk("R7 strobe low", dav_n_out, 0);
    repeat (4) @(negedge clk);
    chk("R8 strobe waits", dav_n_out, 0);
    rdy_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 strobe before due", dav_n_out, 0);
    @(negedge clk);
    chk("R8 strobe released", dav_n_out, 1);
    repeat (3) @(negedge clk);
    rdy_in = 1'b1;
    tx_valid = 1'b1; tx_data = 8'hEE;
    repeat (4) @(negedge clk);
    chk("R9 busy", tx_ready, 0);
    chk("R9 no accept", dav_n_out, 1);
    tx_valid = 1'b0;
    @(negedge clk);
    chk("R9 ready again", tx_ready, 1);
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_out = 1'b0; pin_din = 8'h00; dav_n_in = 1'b1;
    rdy_in = 1'b1; rx_ready = 1'b0; tx_data = 8'h00; tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rdy", rdy_out, 1);
    chk("R1 dav", dav_n_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy", rdy_out, 1);
    chk("R1 dav", dav_n_out, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 0);

    in_byte(8'hA5, 1'b0);
    in_byte(8'h3C, 1'b1);
    in_byte(8'h00, 1'b0);
    in_byte(8'hFF, 1'b1);

    // R6: transmit side ignored in input mode
    @(negedge clk);
    tx_data = 8'h77; tx_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 tx_ready", tx_ready, 0);
    chk("R6 dav_n_out", dav_n_out, 1);
    chk("R6 pin_doe", pin_doe, 0);
    tx_valid = 1'b0;

    @(negedge clk);
    dir_out = 1'b1;
    repeat (3) @(negedge clk);

    // R11: peripheral strobe ignored in output mode
    dav_n_in = 1'b0; pin_din = 8'h99;
    repeat (6) @(negedge clk);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 rdy_out", rdy_out, 1);
    dav_n_in = 1'b1;
    repeat (4) @(negedge clk);

    out_byte(8'h5A);
    out_byte(8'hC3);
    out_byte(8'h81);

    repeat (4) @(negedge clk);
    chk("R3 all bytes read", exp_rx.size(), 0);
    chk("R10 all bytes strobed", exp_tx.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule